// File: doc/BRIEF.md
# SECDED Memory ECC Codec

This block sits between a memory controller and its storage array and guards each 64-bit word with 8 check bits, giving a 72-bit stored word. On the write side it turns a data word into a codeword at once, in the same cycle. A mask register loaded from the port can flip chosen codeword bits on the way out. Software uses the mask to plant correctable or uncorrectable faults and test its error handlers.

On the read side the block takes a 72-bit word and computes a 7-bit position syndrome and an overall parity. A word with one flipped bit comes back repaired. A word with two flipped bits, or with a syndrome that names no real position, is flagged as uncorrectable and passed through unchanged. Every read result appears one cycle after the request, whether or not a repair was made. An uncorrectable read also raises an interrupt for that cycle. The first error seen is kept in a status register until software writes a clear.

Top module: `ecc_codec`

## Requirements
- R1: Codeword bit p (0..71) layout. Bits 1, 2, 4, 8, 16, 32 and 64 are check bits. Data bit i goes to the i-th position in ascending order that is neither 0 nor a power of two. Check bit 2^k makes the XOR over all positions p >= 1 with bit k of p set come out zero. Bit 0 makes the XOR of all 72 bits zero.
- R2: wrCode equals the R1 codeword XOR the injection mask. The mask loads from injMaskIn on a clock edge with injLoad high and is zero after reset.
- R3: A read word with zero syndrome and even overall parity returns its data bits unchanged, with ceOut and ueOut low.
- R4: A read word with odd overall parity and a syndrome s in 1..71 has bit s inverted before the data bits are taken. ceOut is high.
- R5: A read word with odd overall parity and a zero syndrome is correctable: ceOut is high and the data is returned unchanged.
- R6: A read word with even overall parity and a nonzero syndrome is uncorrectable: ueOut is high and the data bits are returned uncorrected.
- R7: A read word with odd overall parity and a syndrome of 72 or more is uncorrectable and is not corrected.
- R8: irqOut is high for exactly the cycles in which an uncorrectable result is presented.
- R9: rdOutValid, rdData, ceOut and ueOut are due one clock after rdValid. Without a read, rdOutValid, ceOut, ueOut and irqOut are low and rdData holds its value.
- R10: statKind (0 none, 1 correctable, 2 uncorrectable) and statSyn ({parity mismatch, syndrome[6:0]}) capture the first error, one clock after its read. Later errors leave them unchanged.
- R11: A clock edge with statClr high empties the status. If an error is read in that same cycle, that error is captured instead.
- R12: After reset, all outputs that come from registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 64 | Data word to encode |
| injLoad | input | 1 | Load injection mask |
| injMaskIn | input | 72 | New injection mask value |
| wrCode | output | 72 | Encoded word with injected flips |
| rdValid | input | 1 | Read word present |
| rdCode | input | 72 | Stored word to check |
| rdOutValid | output | 1 | Read result valid |
| rdData | output | 64 | Corrected data |
| ceOut | output | 1 | Correctable error on this result |
| ueOut | output | 1 | Uncorrectable error on this result |
| irqOut | output | 1 | Uncorrectable-error interrupt |
| statClr | input | 1 | Write-one clear of status |
| statKind | output | 2 | Held error type |
| statSyn | output | 8 | Held parity mismatch and syndrome |

## Verification
The encoder output depends on the current data and the mask register, so it is due in the same cycle: it is compared in the half-cycle after the inputs change. Read results and status are due one edge after the request. The bench model advances its expected registers on that same edge, and every output is compared at the following falling edge. Inputs change only shortly after a rising edge.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;
  localparam int DATA_W = 64;
  localparam int SYN_W  = 7;
  localparam int CODE_W = DATA_W + SYN_W + 1;

  typedef enum logic [1:0] {KIND_NONE = 2'd0, KIND_CE = 2'd1, KIND_UE = 2'd2} errKind_t;

  typedef struct packed {
    logic fixEn;
    logic loadOut;
  } ctlStrobes_t;

  // Position of the idx-th data bit: positions that are neither 0 nor a power of two.
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Positions covered by check bit k.
  function automatic logic [CODE_W-1:0] colMask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p < CODE_W; p++) m[p] = ((p >> k) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/ecc_codec_dp.sv
module ecc_codec_dp
  import ecc_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injLoad,
  input  logic [CODE_W-1:0] injMaskIn,
  output logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] rdCode,
  input  ctlStrobes_t       strobes,
  output logic [SYN_W-1:0]  syn,
  output logic              parOdd,
  output logic [DATA_W-1:0] rdData
);
  logic [CODE_W-1:0] injMask;
  logic [CODE_W-1:0] placed, hamming, fixMask, fixed;
  logic [DATA_W-1:0] rawData, fixedData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) injMask <= '0;
    else if (injLoad) injMask <= injMaskIn;
  end

  always_comb begin
    placed = '0;
    for (int i = 0; i < DATA_W; i++) placed[dataPos(i)] = wrData[i];
    hamming = placed;
    for (int k = 0; k < SYN_W; k++) hamming[1 << k] = ^(placed & colMask(k));
  end

  assign wrCode = {hamming[CODE_W-1:1], ^hamming[CODE_W-1:1]} ^ injMask;

  always_comb begin
    for (int k = 0; k < SYN_W; k++) syn[k] = ^(rdCode & colMask(k));
  end
  assign parOdd = ^rdCode;

  assign fixMask = strobes.fixEn ? (CODE_W'(1) << syn) : '0;
  assign fixed   = rdCode ^ fixMask;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rawData[i]   = rdCode[dataPos(i)];
      fixedData[i] = fixed[dataPos(i)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.loadOut) rdData <= fixedData;
  end

  p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOut && syn == '0 && !parOdd) |=> rdData == $past(rawData));
  p_fix_needs_odd_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fixEn |-> parOdd);
endmodule

// File: rtl/ecc_codec_ctl.sv
module ecc_codec_ctl
  import ecc_codec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdValid,
  input  logic [SYN_W-1:0] syn,
  input  logic             parOdd,
  input  logic             statClr,
  output ctlStrobes_t      strobes,
  output logic             rdOutValid,
  output logic             ceOut,
  output logic             ueOut,
  output logic             irqOut,
  output logic [1:0]       statKind,
  output logic [SYN_W:0]   statSyn
);
  logic synZero, inRange, isCe, isUe, newErr;
  errKind_t newKind;

  assign synZero = (syn == '0);
  assign inRange = (syn < SYN_W'(CODE_W));
  assign isCe    = parOdd && inRange;
  assign isUe    = (!parOdd && !synZero) || (parOdd && !inRange);
  assign newErr  = rdValid && (isCe || isUe);
  assign newKind = isUe ? KIND_UE : KIND_CE;

  assign strobes.fixEn   = rdValid && isCe && !synZero;
  assign strobes.loadOut = rdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOutValid <= 1'b0;
      ceOut      <= 1'b0;
      ueOut      <= 1'b0;
      irqOut     <= 1'b0;
    end else begin
      rdOutValid <= rdValid;
      ceOut      <= rdValid && isCe;
      ueOut      <= rdValid && isUe;
      irqOut     <= rdValid && isUe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statKind <= KIND_NONE;
      statSyn  <= '0;
    end else if (newErr && (statClr || statKind == KIND_NONE)) begin
      statKind <= newKind;
      statSyn  <= {parOdd, syn};
    end else if (statClr) begin
      statKind <= KIND_NONE;
      statSyn  <= '0;
    end
  end

  p_kinds_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ceOut && ueOut));
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rdOutValid);
  p_irq_with_ue_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ueOut && rdOutValid));
  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statKind != KIND_NONE && !statClr) |=> ($stable(statKind) && $stable(statSyn)));
  p_status_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statClr && !rdValid) |=> statKind == KIND_NONE);
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injLoad,
  input  logic [CODE_W-1:0] injMaskIn,
  output logic [CODE_W-1:0] wrCode,
  input  logic              rdValid,
  input  logic [CODE_W-1:0] rdCode,
  output logic              rdOutValid,
  output logic [DATA_W-1:0] rdData,
  output logic              ceOut,
  output logic              ueOut,
  output logic              irqOut,
  input  logic              statClr,
  output logic [1:0]        statKind,
  output logic [SYN_W:0]    statSyn
);
  ctlStrobes_t      strobes;
  logic [SYN_W-1:0] syn;
  logic             parOdd;

  ecc_codec_dp u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .injLoad(injLoad),
    .injMaskIn(injMaskIn), .wrCode(wrCode), .rdCode(rdCode),
    .strobes(strobes), .syn(syn), .parOdd(parOdd), .rdData(rdData)
  );

  ecc_codec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .syn(syn), .parOdd(parOdd),
    .statClr(statClr), .strobes(strobes), .rdOutValid(rdOutValid),
    .ceOut(ceOut), .ueOut(ueOut), .irqOut(irqOut),
    .statKind(statKind), .statSyn(statSyn)
  );
endmodule

// File: tb/ecc_codec_bench.sv
module ecc_codec_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] wrData = '0;
  logic        injLoad = 1'b0;
  logic [71:0] injMaskIn = '0;
  logic [71:0] wrCode;
  logic        rdValid = 1'b0;
  logic [71:0] rdCode = '0;
  logic        rdOutValid;
  logic [63:0] rdData;
  logic        ceOut, ueOut, irqOut;
  logic        statClr = 1'b0;
  logic [1:0]  statKind;
  logic [7:0]  statSyn;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  string curReq = "R12";

  // reference state
  logic [71:0] mMask;
  logic        mValid, mCe, mUe, mIrq;
  logic [63:0] mData;
  logic [1:0]  mKind;
  logic [7:0]  mSyn;

  ecc_codec u_ecc_codec (.*);

  always #10 clk = ~clk;

  function automatic logic [71:0] refEncode(input logic [63:0] d);
    logic [71:0] c;
    int idx, s;
    c = '0; idx = 0; s = 0;
    for (int p = 1; p < 72; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        c[p] = d[idx]; idx++;
      end
    for (int p = 1; p < 72; p++) if (c[p]) s = s ^ p;
    for (int k = 0; k < 7; k++) c[1 << k] = s[k];
    c[0] = ^c[71:1];
    return c;
  endfunction

  function automatic logic [63:0] refData(input logic [71:0] c);
    logic [63:0] d;
    int idx;
    idx = 0; d = '0;
    for (int p = 1; p < 72; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        d[idx] = c[p]; idx++;
      end
    return d;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask <= '0; mValid <= 0; mCe <= 0; mUe <= 0; mIrq <= 0;
      mData <= '0; mKind <= 0; mSyn <= '0;
    end else begin
      int s;
      logic po, ce, ue;
      logic [71:0] c;
      if (injLoad) mMask <= injMaskIn;
      s = 0;
      for (int p = 1; p < 72; p++) if (rdCode[p]) s = s ^ p;
      po = ^rdCode;
      ce = po && s < 72;
      ue = (!po && s != 0) || (po && s >= 72);
      c = rdCode;
      if (ce && s != 0) c[s] = ~c[s];
      mValid <= rdValid;
      mCe <= rdValid && ce;
      mUe <= rdValid && ue;
      mIrq <= rdValid && ue;
      if (rdValid) mData <= refData(c);
      if (rdValid && (ce || ue) && (statClr || mKind == 0)) begin
        mKind <= ue ? 2'd2 : 2'd1;
        mSyn <= {po, 7'(s)};
      end else if (statClr) begin
        mKind <= 0; mSyn <= '0;
      end
    end
  end

  task automatic chk(input string what, input logic [71:0] act, input logic [71:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("wrCode", wrCode, refEncode(wrData) ^ mMask);
      chk("rdOutValid", 72'(rdOutValid), 72'(mValid));
      chk("ceOut", 72'(ceOut), 72'(mCe));
      chk("ueOut", 72'(ueOut), 72'(mUe));
      chk("irqOut", 72'(irqOut), 72'(mIrq));
      chk("rdData", 72'(rdData), 72'(mData));
      chk("statKind", 72'(statKind), 72'(mKind));
      chk("statSyn", 72'(statSyn), 72'(mSyn));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [71:0] c);
    rdValid = 1'b1; rdCode = c; step(); rdValid = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      summary();
    end
  end

  initial begin
    logic [63:0] pats[4];
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hDEAD_BEEF_0123_4567; pats[3] = 64'h8000_0000_0000_0001;
    curReq = "R12";
    repeat (3) step();
    rstN = 1'b1;
    step();
    curReq = "R1";
    foreach (pats[i]) begin wrData = pats[i]; step(); end
    curReq = "R2";
    injLoad = 1'b1; injMaskIn = 72'h1 << 37; step(); injLoad = 1'b0;
    wrData = pats[2]; step();
    injLoad = 1'b1; injMaskIn = (72'h1 << 5) | (72'h1 << 70); step(); injLoad = 1'b0;
    wrData = pats[3]; step();
    injLoad = 1'b1; injMaskIn = '0; step(); injLoad = 1'b0;
    curReq = "R3";
    foreach (pats[i]) rd(refEncode(pats[i]));
    curReq = "R9";
    repeat (3) step();
    curReq = "R4";
    for (int p = 1; p < 72; p++) rd(refEncode(pats[p % 4] ^ 64'(p * 37)) ^ (72'h1 << p));
    curReq = "R11";
    statClr = 1'b1; step(); statClr = 1'b0; step();
    curReq = "R5";
    rd(refEncode(pats[2]) ^ 72'h1);
    curReq = "R10";
    rd(refEncode(pats[1]) ^ 72'h3);
    rd(refEncode(pats[2]) ^ (72'h1 << 9));
    curReq = "R11";
    statClr = 1'b1; rdValid = 1'b1; rdCode = refEncode(pats[3]) ^ (72'h1 << 12) ^ (72'h1 << 40);
    step(); rdValid = 1'b0; statClr = 1'b0;
    statClr = 1'b1; step(); statClr = 1'b0;
    curReq = "R6 R8";
    for (int p = 1; p < 20; p++) rd(refEncode(pats[p % 4]) ^ (72'h1 << p) ^ (72'h1 << (p + 30)));
    rd(refEncode(pats[1]) ^ 72'h1 ^ (72'h1 << 50));
    curReq = "R7";
    rd(refEncode(pats[2]) ^ 72'h1 << 64 ^ 72'h1 << 8 ^ 72'h2);
    rd(refEncode(pats[0]) ^ (72'h1 << 64) ^ (72'h1 << 8) ^ (72'h1 << 1));
    curReq = "R9";
    repeat (3) step();
    summary();
  end
endmodule